// File: doc/BRIEF.md
# Command Packet Parser

This block sits behind a serial byte receiver and turns its byte stream into command traffic. The receiver presents one byte at a time, marked by a one-cycle valid strobe. The block takes the first byte of each message as an opcode. From the opcode it knows how many further bytes belong to the message. It sends the payload bytes to one of three channels: register write, register read or user-defined. Each channel has its own one-cycle enable. The block also holds the register number taken from the message header.

A write message is the opcode, a register number and a fixed number of data bytes. A read message is the opcode and a register number only. A user message is the opcode, a count byte and then that many payload bytes. The remaining length goes into a down counter through a multiplexer, which picks either the fixed write length or the count received in the message.

An opcode that matches none of the three raises an error strobe, and the block goes back to waiting for an opcode. It does not try to resynchronise, so each byte of an unknown message is decoded as a new opcode. The byte source must leave at least four cycles between the starts of consecutive valid strobes, which a serial receiver always does.

Top module: `pkt_parser`

## Requirements
- R1: A synchronous active-low reset clears the register-number output to 0 and holds every strobe low. The first valid byte after reset is decoded as an opcode, even if the reset interrupted a message.
- R2: Opcode 0x01 followed by a register-number byte starts a write. The next WR_LEN bytes (default 4) each raise `wr_en` in the cycle of their valid strobe, with `data_out` equal to that byte. No other byte raises `wr_en`.
- R3: `reg_num` shows the register-number byte of a read or write message from the cycle that byte is valid, and holds it until the next register-number byte.
- R4: Opcode 0x03 followed by a register-number byte raises `rd_en` for exactly one cycle, the cycle that byte is valid. The message carries no payload, so the next byte is decoded as an opcode.
- R5: Opcode 0x05 followed by a count byte N (N > 0) raises `usr_en` once for each of the next N valid bytes, with `data_out` equal to the byte. After the last of them, the next byte is an opcode.
- R6: Opcode 0x05 with a count byte of 0 raises no `usr_en`, and the next byte is decoded as an opcode.
- R7: Any other opcode value raises `err_strobe` for exactly one cycle, two cycles after the cycle its valid strobe was high. It raises no enable, and the next valid byte is decoded as an opcode.
- R8: At most one of `wr_en`, `rd_en` and `usr_en` is high in any cycle, and only in a cycle where `in_valid` is high. `data_out` is 0 whenever no enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_byte | input | DATA_W | Received byte |
| in_valid | input | 1 | One-cycle strobe marking `in_byte` as valid |
| wr_en | output | 1 | Write channel enable, one pulse per data byte |
| rd_en | output | 1 | Read channel enable, one pulse per read message |
| usr_en | output | 1 | User channel enable, one pulse per payload byte |
| data_out | output | DATA_W | Payload byte while an enable is high, else 0 |
| reg_num | output | DATA_W | Register number of the current or last read/write message |
| err_strobe | output | 1 | Unknown-opcode error pulse |

## Verification
The enables, `data_out` and the new `reg_num` value are combinational from the accepted byte. They are due in the same cycle as the valid strobe that carries it. `err_strobe` is due two cycles after the offending opcode's strobe, one cycle for registering the opcode and one for comparing it. The bench drives inputs shortly after a rising edge and samples every output at the falling edge. It compares each sample with a behavioural model that advances on the rising edge, so each result is checked in exactly the cycle it is due. Pulse counts per message check the exact number of write and user enables, including the zero-count case.

// File: rtl/pkt_parser_pkg.sv
// Shared types for the command packet parser: controller states,
// opcode classes and the opcode byte values.
package pkt_parser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_REGNUM,
        ST_COUNT,
        ST_WRITE,
        ST_USER,
        ST_ERROR
    } state_t;

    typedef enum logic [1:0] {
        K_WRITE,
        K_READ,
        K_USER,
        K_BAD
    } kind_t;

    localparam logic [7:0] OPC_WRITE = 8'h01;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_USER  = 8'h05;

endpackage

// File: rtl/pkt_opcode_decode.sv
// Opcode classifier. Maps a registered opcode byte onto one of the
// message classes. Purely combinational; assumes DATA_W >= 8.
module pkt_opcode_decode
    import pkt_parser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opcode,
    output kind_t             kind
);

    // Compare the opcode against the three known values.
    always_comb begin
        if (opcode == DATA_W'(OPC_WRITE))      kind = K_WRITE;
        else if (opcode == DATA_W'(OPC_READ))  kind = K_READ;
        else if (opcode == DATA_W'(OPC_USER))  kind = K_USER;
        else                                   kind = K_BAD;
    end

endmodule

// File: rtl/pkt_len_counter.sv
// Remaining-length counter. On load it takes either the fixed write
// length or the count byte received in the message, as picked by
// use_count. It decrements once per accepted payload byte. is_last flags
// the final byte. Assumes load and dec are never high together.
module pkt_len_counter #(
    parameter int DATA_W = 8,
    parameter int WR_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              use_count,
    input  logic [DATA_W-1:0] count_in,
    input  logic              dec,
    output logic              is_last
);

    localparam int LEN_W = $clog2(WR_LEN + 1);
    localparam int CNT_W = (DATA_W > LEN_W) ? DATA_W : LEN_W;

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;

    // Pick the fixed write length or the received count.
    always_comb begin
        load_val = use_count ? CNT_W'(count_in) : CNT_W'(WR_LEN);
    end

    // Load, count down, or clear under reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        remain_q <= '0;
        else if (load)     remain_q <= load_val;
        else if (dec)      remain_q <= remain_q - 1'b1;
    end

    // Flag the final payload byte.
    always_comb begin
        is_last = (remain_q == CNT_W'(1));
    end

endmodule

// File: rtl/pkt_parser_fsm.sv
// Message controller. Registers the opcode, spends one cycle comparing
// it, takes the header byte (register number or count), then walks the
// payload under the length counter. Assumes valid strobes are at least
// four cycles apart, so no byte arrives during the compare or error
// cycles.
module pkt_parser_fsm
    import pkt_parser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_valid,
    input  kind_t             kind,
    input  logic              is_last,
    output logic [DATA_W-1:0] opcode_q,
    output logic [DATA_W-1:0] reg_q,
    output state_t            state,
    output logic              cnt_load,
    output logic              cnt_use_count,
    output logic              cnt_dec
);

    state_t state_n;
    logic   count_zero;

    // Detect an empty user message.
    always_comb begin
        count_zero = (in_byte == '0);
    end

    // Next-state logic.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_n = ST_OPCODE;
            ST_OPCODE: begin
                unique case (kind)
                    K_WRITE, K_READ: state_n = ST_REGNUM;
                    K_USER:          state_n = ST_COUNT;
                    default:         state_n = ST_ERROR;
                endcase
            end
            ST_REGNUM: if (in_valid) state_n = (kind == K_READ) ? ST_IDLE : ST_WRITE;
            ST_COUNT:  if (in_valid) state_n = count_zero ? ST_IDLE : ST_USER;
            ST_WRITE,
            ST_USER:   if (in_valid && is_last) state_n = ST_IDLE;
            ST_ERROR:  state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Opcode capture in IDLE.
    always_ff @(posedge clk) begin
        if (!rst_n)                              opcode_q <= '0;
        else if (state == ST_IDLE && in_valid)   opcode_q <= in_byte;
    end

    // Register-number capture from the header byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                              reg_q <= '0;
        else if (state == ST_REGNUM && in_valid) reg_q <= in_byte;
    end

    // Length counter controls.
    always_comb begin
        cnt_use_count = (state == ST_COUNT);
        cnt_load      = in_valid &&
                        ((state == ST_REGNUM && kind == K_WRITE) ||
                         (state == ST_COUNT && !count_zero));
        cnt_dec       = in_valid && (state == ST_WRITE || state == ST_USER);
    end

endmodule

// File: rtl/pkt_parser.sv
// Command packet parser top. Connects the opcode decoder, the message
// controller and the length counter. Drives the per-byte channel enables
// as the active state ANDed with the input strobe. Assumes the byte
// source leaves at least four cycles between valid strobes.
module pkt_parser
    import pkt_parser_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WR_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              wr_en,
    output logic              rd_en,
    output logic              usr_en,
    output logic [DATA_W-1:0] data_out,
    output logic [DATA_W-1:0] reg_num,
    output logic              err_strobe
);

    kind_t             kind;
    state_t            state;
    logic [DATA_W-1:0] opcode_q;
    logic [DATA_W-1:0] reg_q;
    logic              is_last;
    logic              cnt_load;
    logic              cnt_use_count;
    logic              cnt_dec;

    pkt_opcode_decode #(.DATA_W(DATA_W)) u_decode (
        .opcode (opcode_q),
        .kind   (kind)
    );

    pkt_parser_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_byte       (in_byte),
        .in_valid      (in_valid),
        .kind          (kind),
        .is_last       (is_last),
        .opcode_q      (opcode_q),
        .reg_q         (reg_q),
        .state         (state),
        .cnt_load      (cnt_load),
        .cnt_use_count (cnt_use_count),
        .cnt_dec       (cnt_dec)
    );

    pkt_len_counter #(.DATA_W(DATA_W), .WR_LEN(WR_LEN)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .use_count (cnt_use_count),
        .count_in  (in_byte),
        .dec       (cnt_dec),
        .is_last   (is_last)
    );

    // Channel enables, gated payload, and the error flag.
    always_comb begin
        wr_en      = in_valid && (state == ST_WRITE);
        usr_en     = in_valid && (state == ST_USER);
        rd_en      = in_valid && (state == ST_REGNUM) && (kind == K_READ);
        data_out   = (wr_en || usr_en) ? in_byte : '0;
        err_strobe = (state == ST_ERROR);
    end

    // Register number: live during the header byte, held afterwards.
    always_comb begin
        reg_num = (in_valid && state == ST_REGNUM) ? in_byte : reg_q;
    end

endmodule

// File: rtl/pkt_parser_chk.sv
// Property checker for the command packet parser, bound to the top.
// Watches only ports; keeps one run counter for the write-burst bound.
module pkt_parser_chk #(
    parameter int DATA_W = 8,
    parameter int WR_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_byte,
    input logic              in_valid,
    input logic              wr_en,
    input logic              rd_en,
    input logic              usr_en,
    input logic [DATA_W-1:0] data_out,
    input logic              err_strobe
);

    localparam int RUN_W = $clog2(WR_LEN + 2);
    logic [RUN_W-1:0] wr_run;

    // Count write enables since the last byte that raised no enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          wr_run <= '0;
        else if (in_valid && !(wr_en || rd_en || usr_en))    wr_run <= '0;
        else if (wr_en && wr_run != RUN_W'(WR_LEN + 1))      wr_run <= wr_run + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !err_strobe); // R1
    AST_WR_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) wr_run <= RUN_W'(WR_LEN)); // R2
    AST_WR_DATA:     assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> data_out == in_byte); // R2
    AST_USR_DATA:    assert property (@(posedge clk) disable iff (!rst_n) usr_en |-> data_out == in_byte); // R5
    AST_ERR_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) err_strobe |=> !err_strobe); // R7
    AST_ERR_NO_EN:   assert property (@(posedge clk) disable iff (!rst_n) err_strobe |-> !(wr_en || rd_en || usr_en)); // R7
    AST_EN_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0({wr_en, rd_en, usr_en})); // R8
    AST_EN_VALID:    assert property (@(posedge clk) disable iff (!rst_n) (wr_en || rd_en || usr_en) |-> in_valid); // R8
    AST_DATA_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) !(wr_en || usr_en) |-> data_out == '0); // R8

endmodule

bind pkt_parser pkt_parser_chk #(.DATA_W(DATA_W), .WR_LEN(WR_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_byte    (in_byte),
    .in_valid   (in_valid),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .usr_en     (usr_en),
    .data_out   (data_out),
    .err_strobe (err_strobe)
);

// File: tb/test_pkt_parser.sv
// Bench for the command packet parser: a behavioural message model
// advanced on the rising edge, compared with the outputs every falling edge.
module test_pkt_parser;

    localparam int DW = 8;
    localparam int WL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_byte = '0;
    logic          in_valid = 1'b0;
    logic          wr_en, rd_en, usr_en, err_strobe;
    logic [DW-1:0] data_out, reg_num;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Model state: 0 idle, 1 write header, 2 read header, 3 count, 4 write data, 5 user data.
    int     m_mode = 0;
    int     m_rem = 0;
    int     m_errcd = 0;
    int     m_reg = 0;
    int     wr_pulses = 0;
    int     usr_pulses = 0;
    int     rd_pulses = 0;
    int     err_pulses = 0;

    always #10 clk = ~clk;

    pkt_parser #(.DATA_W(DW), .WR_LEN(WL)) i_pkt_parser (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .wr_en(wr_en), .rd_en(rd_en), .usr_en(usr_en), .data_out(data_out),
        .reg_num(reg_num), .err_strobe(err_strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_rem = 0; m_errcd = 0; m_reg = 0;
        end else begin
            if (m_errcd > 0) m_errcd--;
            if (in_valid) begin
                case (m_mode)
                    0: begin
                        if (in_byte == 8'h01)      m_mode = 1;
                        else if (in_byte == 8'h03) m_mode = 2;
                        else if (in_byte == 8'h05) m_mode = 3;
                        else                       m_errcd = 2;
                    end
                    1: begin m_reg = in_byte; m_rem = WL; m_mode = 4; end
                    2: begin m_reg = in_byte; m_mode = 0; end
                    3: begin
                        if (in_byte == 0) m_mode = 0;
                        else begin m_rem = in_byte; m_mode = 5; end
                    end
                    default: begin
                        m_rem--;
                        if (m_rem == 0) m_mode = 0;
                    end
                endcase
            end
        end
    end

    // Compare every output at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int e_wr, e_rd, e_usr, e_dat, e_reg, e_err;
            e_wr  = (in_valid && m_mode == 4) ? 1 : 0;
            e_usr = (in_valid && m_mode == 5) ? 1 : 0;
            e_rd  = (in_valid && m_mode == 2) ? 1 : 0;
            e_dat = (e_wr || e_usr) ? int'(in_byte) : 0;
            e_reg = (in_valid && (m_mode == 1 || m_mode == 2)) ? int'(in_byte) : m_reg;
            e_err = (m_errcd == 1) ? 1 : 0;
            check("R2 wr_en", int'(wr_en), e_wr);
            check("R4 rd_en", int'(rd_en), e_rd);
            check("R5 usr_en", int'(usr_en), e_usr);
            check("R8 data_out", int'(data_out), e_dat);
            check("R3 reg_num", int'(reg_num), e_reg);
            check("R7 err_strobe", int'(err_strobe), e_err);
            if (wr_en)  wr_pulses++;
            if (usr_en) usr_pulses++;
            if (rd_en)  rd_pulses++;
            if (err_strobe) err_pulses++;
        end
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #2;
        in_byte = b; in_valid = 1'b1;
        @(posedge clk); #2;
        in_valid = 1'b0; in_byte = '0;
        repeat (2) @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic clear_counts();
        wr_pulses = 0; usr_pulses = 0; rd_pulses = 0; err_pulses = 0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        idle(3); #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 reg_num after reset", int'(reg_num), 0);
        check("R1 strobes after reset", int'({wr_en, rd_en, usr_en, err_strobe}), 0);

        // R2/R3: write 0xDEADBEEF to register 6.
        clear_counts();
        send(8'h01); send(8'h06); send(8'hDE); send(8'hAD); send(8'hBE); send(8'hEF);
        idle(2);
        check("R2 write pulse count", wr_pulses, WL);
        check("R3 reg_num held", int'(reg_num), 6);

        // R4: read register 2, then a read of 9 to show no payload was taken.
        clear_counts();
        send(8'h03); send(8'h02); send(8'h03); send(8'h09);
        idle(2);
        check("R4 read pulse count", rd_pulses, 2);
        check("R3 reg_num after read", int'(reg_num), 9);

        // R5: user message of eight bytes.
        clear_counts();
        send(8'h05); send(8'h08);
        for (int i = 0; i < 8; i++) send(8'hA0 + 8'(i));
        send(8'h03); send(8'h04);
        idle(2);
        check("R5 user pulse count", usr_pulses, 8);
        check("R5 next byte is opcode", rd_pulses, 1);

        // R6: empty user message.
        clear_counts();
        send(8'h05); send(8'h00); send(8'h03); send(8'h0B);
        idle(2);
        check("R6 empty user pulses", usr_pulses, 0);
        check("R6 next byte is opcode", rd_pulses, 1);

        // R7: unknown opcodes, each byte flagged, then a valid write.
        clear_counts();
        send(8'h07); send(8'hAA); send(8'h00);
        send(8'h01); send(8'h11); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
        idle(2);
        check("R7 error pulse count", err_pulses, 3);
        check("R7 write after error", wr_pulses, WL);
        check("R7 no stray user/read", usr_pulses + rd_pulses, 0);

        // R1: reset in the middle of a write, then the next byte is an opcode.
        clear_counts();
        send(8'h01); send(8'h05); send(8'h55);
        @(posedge clk); #2; rst_n = 1'b0;
        idle(2); #2; rst_n = 1'b1;
        @(negedge clk);
        check("R1 reg_num cleared", int'(reg_num), 0);
        send(8'h03); send(8'h0C);
        idle(2);
        check("R1 read after mid-message reset", rd_pulses, 1);
        check("R1 write pulses before reset", wr_pulses, 1);

        done = 1;
        report();
    end

endmodule